// File: doc/BRIEF.md
# Serial Port Status Flag and Interrupt Controller

This block holds the status flags of one asynchronous serial channel and combines them into a single interrupt request. The receiver, the transmitter and the two DMA channels report events to it as one-cycle pulses or as steady levels. The block decides, for each flag, when the flag is set, when it is cleared and whether it is latched or simply follows a live input.

Software controls the block through command strobes. An enable write sets bits of the interrupt mask and a disable write clears them; bits written as zero are left unchanged. A status-reset command clears the sticky error flags. A time-out restart command clears the time-out flag. The block drives the 10-bit status word, the 10-bit mask and a registered interrupt level.

All inputs are synchronous to `clk`. `rst` is a synchronous, active-high reset.

Top module: `ssi_status_irq`

## Requirements
- R1: The status word uses fixed bit positions: 0 receive-ready, 1 transmit-ready, 2 break, 3 receive-DMA-done, 4 transmit-DMA-done, 5 overrun, 6 framing error, 7 parity error, 8 time-out, 9 transmitter-empty. Bits 1, 3, 4 and 9 are not latched. They equal `tx_hold_free`, `dma_rx_done`, `dma_tx_done` and `tx_idle` in the same cycle.
- R2: Receive-ready becomes 1 in the cycle after `rx_char_load` and 0 in the cycle after `rx_hold_read`. It reads 0 while `rx_enable` is low. The latched value reappears when `rx_enable` returns high.
- R3: Overrun becomes 1 in the cycle after an `rx_char_load` that arrives while the latched receive-ready is 1. It stays 1 until a status-reset command.
- R4: Framing error becomes 1 in the cycle after `rx_stop_strobe` with `rx_stop_level` equal to 0. It stays 1 until a status-reset command.
- R5: On `rx_par_strobe`, parity error is set in either of two cases. When `multidrop_mode` is 0, it is set if `rx_par_level` differs from `rx_par_expect`. When `multidrop_mode` is 1, it is set if `rx_par_level` is 1. It stays 1 until a status-reset command.
- R6: Break becomes 1 in the cycle after `rx_brk_begin` or `rx_brk_end`. It stays 1 until a status-reset command.
- R7: Time-out becomes 1 in the cycle after `rx_to_expire` and clears after `cmd_to_restart`. While `rx_to_disabled` is high, an expiry is ignored and the flag is cleared on the next edge.
- R8: `cmd_status_reset` clears break, overrun, framing error and parity error on the next edge. It leaves receive-ready and time-out unchanged.
- R9: When a set event and a clear command reach the same latched flag in the same cycle, the flag ends up 1.
- R10: On `ien_we`, mask bits written as 1 are set. On `idis_we`, mask bits written as 1 are cleared. Bits written as 0 are unchanged. If both strobes target the same bit in the same cycle, the bit ends up 0.
- R11: `irq_o` is 1 in the cycle after any cycle in which (status AND mask) is non-zero, and 0 otherwise.
- R12: After reset, every latched flag, the mask and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receiver enabled level |
| rx_char_load | input | 1 | Pulse: character moved into receive holding register |
| rx_hold_read | input | 1 | Pulse: receive holding register read |
| rx_brk_begin | input | 1 | Pulse: break condition detected |
| rx_brk_end | input | 1 | Pulse: end of break detected |
| rx_stop_strobe | input | 1 | Pulse: stop bit sampled |
| rx_stop_level | input | 1 | Sampled stop bit value |
| rx_par_strobe | input | 1 | Pulse: parity bit sampled |
| rx_par_level | input | 1 | Sampled parity bit value |
| rx_par_expect | input | 1 | Parity value computed from the data |
| multidrop_mode | input | 1 | Parity bit carries address marker |
| rx_to_expire | input | 1 | Pulse: receive time-out counter expired |
| rx_to_disabled | input | 1 | Programmed time-out value is zero |
| cmd_to_restart | input | 1 | Time-out restart command strobe |
| cmd_status_reset | input | 1 | Status-reset command strobe |
| tx_hold_free | input | 1 | Transmit holding register empty level |
| tx_idle | input | 1 | Transmitter fully idle level |
| dma_rx_done | input | 1 | Receive DMA end-of-transfer level |
| dma_tx_done | input | 1 | Transmit DMA end-of-transfer level |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_bits | input | 10 | Interrupt enable write data |
| idis_we | input | 1 | Interrupt disable write strobe |
| idis_bits | input | 10 | Interrupt disable write data |
| status_o | output | 10 | Status word |
| mask_o | output | 10 | Interrupt mask readback |
| irq_o | output | 1 | Interrupt request level |

## Verification
On every cycle, the embedded assertions check a fixed set of local rules. A set event leaves its flag at 1 (this covers set-wins). A latched flag holds unless it is cleared. An overrun follows a load into a full holding register. A disabled time-out stays at 0 and a disabled receiver reads 0. Mask writes take effect, and the interrupt follows status AND mask one cycle later.

Some rules need the bench's scenarios and its reference model. These are which command clears which flag and the parity rule in multidrop mode. Others are the reappearance of receive-ready when the receiver is re-enabled, and a disable write beating an enable write to the same bit. The reset values are also checked only by the bench.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
    localparam int NFLAG = 10;

    // status word bit positions (fixed, software decodes them)
    localparam int B_RXRDY   = 0;
    localparam int B_TXRDY   = 1;
    localparam int B_BRK     = 2;
    localparam int B_DMARX   = 3;
    localparam int B_DMATX   = 4;
    localparam int B_OVR     = 5;
    localparam int B_FRM     = 6;
    localparam int B_PAR     = 7;
    localparam int B_TMO     = 8;
    localparam int B_TXEMPTY = 9;

    // latched flag indices inside the receive flag bank
    localparam int NLATCH  = 6;
    localparam int L_RXRDY = 0;
    localparam int L_OVR   = 1;
    localparam int L_FRM   = 2;
    localparam int L_PAR   = 3;
    localparam int L_BRK   = 4;
    localparam int L_TMO   = 5;

    typedef struct packed {
        logic char_load;
        logic hold_read;
        logic brk_begin;
        logic brk_end;
        logic stop_strobe;
        logic stop_level;
        logic par_strobe;
        logic par_level;
        logic par_expect;
        logic multidrop;
        logic to_expire;
        logic to_disabled;
    } rx_evt_t;

    typedef struct packed {
        logic status_reset;
        logic to_restart;
    } cmd_t;

    typedef struct packed {
        logic tmo;
        logic brk;
        logic par;
        logic frm;
        logic ovr;
        logic rxrdy;
    } latched_t;

    function automatic logic parity_bad(input logic lvl, input logic expct,
                                        input logic md);
        return md ? lvl : (lvl ^ expct);
    endfunction

    function automatic logic [NFLAG-1:0] pack_status(
        input latched_t lf, input logic rx_en, input logic txrdy,
        input logic txempty, input logic dmarx, input logic dmatx);
        logic [NFLAG-1:0] s;
        s            = '0;
        s[B_RXRDY]   = lf.rxrdy & rx_en;
        s[B_TXRDY]   = txrdy;
        s[B_BRK]     = lf.brk;
        s[B_DMARX]   = dmarx;
        s[B_DMATX]   = dmatx;
        s[B_OVR]     = lf.ovr;
        s[B_FRM]     = lf.frm;
        s[B_PAR]     = lf.par;
        s[B_TMO]     = lf.tmo;
        s[B_TXEMPTY] = txempty;
        return s;
    endfunction
endpackage

// File: rtl/ssi_flag.sv
module ssi_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_r;

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= 1'b0;
        else if (set_i)
            q_r <= 1'b1;
        else if (clr_i)
            q_r <= 1'b0;
    end

    assign q_o = q_r;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o); // R9
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (q_o && !clr_i) |=> q_o); // R8
endmodule

// File: rtl/ssi_rx_flags.sv
module ssi_rx_flags
    import ssi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rx_evt_t  evt_i,
    input  cmd_t     cmd_i,
    output latched_t flags_o
);
    logic [NLATCH-1:0] set_v;
    logic [NLATCH-1:0] clr_v;
    logic [NLATCH-1:0] q_v;

    always_comb begin
        set_v = '0;
        clr_v = '0;
        // receive-ready: data path event pair
        set_v[L_RXRDY] = evt_i.char_load;
        clr_v[L_RXRDY] = evt_i.hold_read;
        // overrun: load into a still-full holding register
        set_v[L_OVR]   = evt_i.char_load & q_v[L_RXRDY];
        clr_v[L_OVR]   = cmd_i.status_reset;
        // framing: stop bit sampled low
        set_v[L_FRM]   = evt_i.stop_strobe & ~evt_i.stop_level;
        clr_v[L_FRM]   = cmd_i.status_reset;
        // parity: wrong bit, or address marker in multidrop mode
        set_v[L_PAR]   = evt_i.par_strobe &
                         parity_bad(evt_i.par_level, evt_i.par_expect,
                                    evt_i.multidrop);
        clr_v[L_PAR]   = cmd_i.status_reset;
        // break: both edges of the break condition
        set_v[L_BRK]   = evt_i.brk_begin | evt_i.brk_end;
        clr_v[L_BRK]   = cmd_i.status_reset;
        // time-out: suppressed entirely when disabled
        set_v[L_TMO]   = evt_i.to_expire & ~evt_i.to_disabled;
        clr_v[L_TMO]   = cmd_i.to_restart | evt_i.to_disabled;
    end

    for (genvar g = 0; g < NLATCH; g++) begin : g_flag
        ssi_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_v[g]),
            .clr_i (clr_v[g]),
            .q_o   (q_v[g])
        );
    end

    always_comb begin
        flags_o       = '0;
        flags_o.rxrdy = q_v[L_RXRDY];
        flags_o.ovr   = q_v[L_OVR];
        flags_o.frm   = q_v[L_FRM];
        flags_o.par   = q_v[L_PAR];
        flags_o.brk   = q_v[L_BRK];
        flags_o.tmo   = q_v[L_TMO];
    end

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (evt_i.char_load && flags_o.rxrdy) |=> flags_o.ovr); // R3
    AST_RXRDY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (evt_i.hold_read && !evt_i.char_load) |=> !flags_o.rxrdy); // R2
    AST_TMO_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (evt_i.to_disabled && $past(evt_i.to_disabled)) |-> !flags_o.tmo); // R7
    AST_TMO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.to_restart && !evt_i.to_expire) |=> !flags_o.tmo); // R7
endmodule

// File: rtl/ssi_mask_reg.sv
module ssi_mask_reg
    import ssi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_we,
    input  logic [NFLAG-1:0] en_bits,
    input  logic             dis_we,
    input  logic [NFLAG-1:0] dis_bits,
    output logic [NFLAG-1:0] mask_o
);
    logic [NFLAG-1:0] mask_r;
    logic [NFLAG-1:0] set_m;
    logic [NFLAG-1:0] clr_m;

    always_comb begin
        set_m = en_we  ? en_bits  : '0;
        clr_m = dis_we ? dis_bits : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_r <= '0;
        else
            mask_r <= (mask_r | set_m) & ~clr_m;
    end

    assign mask_o = mask_r;

    AST_MASK_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (en_we && !dis_we) |=> ((mask_o & $past(en_bits)) == $past(en_bits))); // R10
    AST_MASK_DISABLE: assert property (@(posedge clk) disable iff (rst)
        dis_we |=> ((mask_o & $past(dis_bits)) == '0)); // R10
    AST_MASK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!en_we && !dis_we) |=> $stable(mask_o)); // R10
endmodule

// File: rtl/ssi_irq_gen.sv
module ssi_irq_gen
    import ssi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] status_i,
    input  logic [NFLAG-1:0] mask_i,
    output logic             irq_o
);
    logic irq_r;

    always_ff @(posedge clk) begin
        if (rst)
            irq_r <= 1'b0;
        else
            irq_r <= |(status_i & mask_i);
    end

    assign irq_o = irq_r;

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
        (|(status_i & mask_i)) |=> irq_o); // R11
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
        ((status_i & mask_i) == '0) |=> !irq_o); // R11
endmodule

// File: rtl/ssi_status_irq.sv
module ssi_status_irq
    import ssi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_enable,
    input  logic             rx_char_load,
    input  logic             rx_hold_read,
    input  logic             rx_brk_begin,
    input  logic             rx_brk_end,
    input  logic             rx_stop_strobe,
    input  logic             rx_stop_level,
    input  logic             rx_par_strobe,
    input  logic             rx_par_level,
    input  logic             rx_par_expect,
    input  logic             multidrop_mode,
    input  logic             rx_to_expire,
    input  logic             rx_to_disabled,
    input  logic             cmd_to_restart,
    input  logic             cmd_status_reset,
    input  logic             tx_hold_free,
    input  logic             tx_idle,
    input  logic             dma_rx_done,
    input  logic             dma_tx_done,
    input  logic             ien_we,
    input  logic [NFLAG-1:0] ien_bits,
    input  logic             idis_we,
    input  logic [NFLAG-1:0] idis_bits,
    output logic [NFLAG-1:0] status_o,
    output logic [NFLAG-1:0] mask_o,
    output logic             irq_o
);
    rx_evt_t          evt;
    cmd_t             cmd;
    latched_t         lflags;
    logic [NFLAG-1:0] status_w;
    logic [NFLAG-1:0] mask_w;

    always_comb begin
        evt.char_load   = rx_char_load;
        evt.hold_read   = rx_hold_read;
        evt.brk_begin   = rx_brk_begin;
        evt.brk_end     = rx_brk_end;
        evt.stop_strobe = rx_stop_strobe;
        evt.stop_level  = rx_stop_level;
        evt.par_strobe  = rx_par_strobe;
        evt.par_level   = rx_par_level;
        evt.par_expect  = rx_par_expect;
        evt.multidrop   = multidrop_mode;
        evt.to_expire   = rx_to_expire;
        evt.to_disabled = rx_to_disabled;
        cmd.status_reset = cmd_status_reset;
        cmd.to_restart   = cmd_to_restart;
    end

    ssi_rx_flags u_rx_flags (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt),
        .cmd_i   (cmd),
        .flags_o (lflags)
    );

    ssi_mask_reg u_mask (
        .clk      (clk),
        .rst      (rst),
        .en_we    (ien_we),
        .en_bits  (ien_bits),
        .dis_we   (idis_we),
        .dis_bits (idis_bits),
        .mask_o   (mask_w)
    );

    always_comb begin
        status_w = pack_status(lflags, rx_enable, tx_hold_free, tx_idle,
                               dma_rx_done, dma_tx_done);
    end

    ssi_irq_gen u_irq (
        .clk      (clk),
        .rst      (rst),
        .status_i (status_w),
        .mask_i   (mask_w),
        .irq_o    (irq_o)
    );

    assign status_o = status_w;
    assign mask_o   = mask_w;

    AST_RXRDY_GATED: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |-> !status_o[B_RXRDY]); // R2
    AST_FRAME_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_stop_strobe && !rx_stop_level) |=> status_o[B_FRM]); // R4
    AST_BREAK_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_brk_begin || rx_brk_end) |=> status_o[B_BRK]); // R6
endmodule

// File: tb/tb_ssi_status_irq.sv
module tb_ssi_status_irq;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 10;
    localparam int RAND_CYCLES = 3000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_enable, rx_char_load, rx_hold_read, rx_brk_begin, rx_brk_end;
    logic rx_stop_strobe, rx_stop_level, rx_par_strobe, rx_par_level;
    logic rx_par_expect, multidrop_mode, rx_to_expire, rx_to_disabled;
    logic cmd_to_restart, cmd_status_reset, tx_hold_free, tx_idle;
    logic dma_rx_done, dma_tx_done, ien_we, idis_we;
    logic [NF-1:0] ien_bits, idis_bits, status_o, mask_o;
    logic irq_o;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    // reference model state
    logic m_rxrdy, m_ovr, m_frm, m_par, m_brk, m_tmo, m_irq;
    logic [NF-1:0] m_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssi_status_irq dut (.*);

    task automatic chk(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic string bit_req(input int b);
        case (b)
            0: return "R2 rxrdy";
            2: return "R6 break";
            5: return "R3 overrun";
            6: return "R4 framing";
            7: return "R5 parity";
            8: return "R7 timeout";
            default: return "R1 live level";
        endcase
    endfunction

    function automatic logic [NF-1:0] exp_status();
        logic [NF-1:0] s;
        s = '0;
        s[0] = m_rxrdy & rx_enable;
        s[1] = tx_hold_free;
        s[2] = m_brk;
        s[3] = dma_rx_done;
        s[4] = dma_tx_done;
        s[5] = m_ovr;
        s[6] = m_frm;
        s[7] = m_par;
        s[8] = m_tmo;
        s[9] = tx_idle;
        return s;
    endfunction

    function automatic logic par_fault();
        if (multidrop_mode) return rx_par_level;
        return rx_par_level != rx_par_expect;
    endfunction

    task automatic model_reset();
        m_rxrdy = 0; m_ovr = 0; m_frm = 0; m_par = 0;
        m_brk = 0; m_tmo = 0; m_irq = 0; m_mask = '0;
    endtask

    task automatic idle();
        rx_enable = 1; rx_char_load = 0; rx_hold_read = 0; rx_brk_begin = 0;
        rx_brk_end = 0; rx_stop_strobe = 0; rx_stop_level = 1; rx_par_strobe = 0;
        rx_par_level = 0; rx_par_expect = 0; multidrop_mode = 0; rx_to_expire = 0;
        rx_to_disabled = 0; cmd_to_restart = 0; cmd_status_reset = 0;
        tx_hold_free = 0; tx_idle = 0; dma_rx_done = 0; dma_tx_done = 0;
        ien_we = 0; idis_we = 0; ien_bits = '0; idis_bits = '0;
    endtask

    // inputs are set; compare outputs, advance model, pass one clock edge
    task automatic step();
        logic [NF-1:0] es;
        logic [NF-1:0] nm;
        #1;
        es = exp_status();
        for (int b = 0; b < NF; b++) chk(bit_req(b), status_o[b], es[b]);
        chk("R10 mask", mask_o, m_mask);
        chk("R11 irq", irq_o, m_irq);
        nm = (m_mask | (ien_we ? ien_bits : '0)) & ~(idis_we ? idis_bits : '0);
        m_irq = |(es & m_mask);
        m_ovr = (rx_char_load & m_rxrdy) | (m_ovr & ~cmd_status_reset);
        m_rxrdy = rx_char_load | (m_rxrdy & ~rx_hold_read);
        m_frm = (rx_stop_strobe & ~rx_stop_level) | (m_frm & ~cmd_status_reset);
        m_par = (rx_par_strobe & par_fault()) | (m_par & ~cmd_status_reset);
        m_brk = rx_brk_begin | rx_brk_end | (m_brk & ~cmd_status_reset);
        m_tmo = (rx_to_expire & ~rx_to_disabled) |
                (m_tmo & ~cmd_to_restart & ~rx_to_disabled);
        m_mask = nm;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic randomize_inputs();
        rx_enable        = ($urandom % 10) != 0;
        rx_char_load     = ($urandom % 4) == 0;
        rx_hold_read     = ($urandom % 4) == 0;
        rx_brk_begin     = ($urandom % 12) == 0;
        rx_brk_end       = ($urandom % 12) == 0;
        rx_stop_strobe   = ($urandom % 5) == 0;
        rx_stop_level    = ($urandom % 3) != 0;
        rx_par_strobe    = ($urandom % 5) == 0;
        rx_par_level     = 1'($urandom);
        rx_par_expect    = 1'($urandom);
        multidrop_mode   = ($urandom % 3) == 0;
        rx_to_expire     = ($urandom % 8) == 0;
        rx_to_disabled   = ($urandom % 10) == 0;
        cmd_to_restart   = ($urandom % 6) == 0;
        cmd_status_reset = ($urandom % 7) == 0;
        tx_hold_free     = 1'($urandom);
        tx_idle          = 1'($urandom);
        dma_rx_done      = ($urandom % 4) == 0;
        dma_tx_done      = ($urandom % 4) == 0;
        ien_we           = ($urandom % 6) == 0;
        ien_bits         = NF'($urandom);
        idis_we          = ($urandom % 6) == 0;
        idis_bits        = NF'($urandom);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1a2b);
        idle();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R12 reset state
        chk("R12 status after reset", status_o & ~10'h21a, 0);
        chk("R12 mask after reset", mask_o, 0);
        chk("R12 irq after reset", irq_o, 0);

        // R9 load and read together keep rxrdy set
        rx_char_load = 1; step();
        idle(); rx_char_load = 1; rx_hold_read = 1; step();
        idle(); #1;
        chk("R9 load beats read", status_o[0], 1);
        chk("R3 load while full sets overrun", status_o[5], 1);
        // R2 receiver disabled hides rxrdy, re-enable shows it
        rx_enable = 0; #1;
        chk("R2 rxrdy hidden while disabled", status_o[0], 0);
        step();
        idle(); #1;
        chk("R2 rxrdy back after enable", status_o[0], 1);
        // R8 status reset clears overrun but not rxrdy
        rx_stop_strobe = 1; rx_stop_level = 0; step();
        idle(); cmd_status_reset = 1; step();
        idle(); #1;
        chk("R8 overrun cleared", status_o[5], 0);
        chk("R8 framing cleared", status_o[6], 0);
        chk("R8 rxrdy kept", status_o[0], 1);
        // R9 framing set and status reset together
        rx_stop_strobe = 1; rx_stop_level = 0; cmd_status_reset = 1; step();
        idle(); #1;
        chk("R9 framing set beats reset", status_o[6], 1);
        // R5 multidrop: high parity bit flags even when it matches
        cmd_status_reset = 1; step();
        idle(); multidrop_mode = 1; rx_par_strobe = 1; rx_par_level = 1;
        rx_par_expect = 1; step();
        idle(); #1;
        chk("R5 multidrop high parity", status_o[7], 1);
        cmd_status_reset = 1; step();
        idle(); rx_par_strobe = 1; rx_par_level = 1; rx_par_expect = 1; step();
        idle(); #1;
        chk("R5 matching parity no error", status_o[7], 0);
        // R6 end of break alone sets break
        rx_brk_end = 1; step();
        idle(); #1;
        chk("R6 end of break", status_o[2], 1);
        // R7 disabled time-out ignores expiry, restart clears
        rx_to_disabled = 1; rx_to_expire = 1; step();
        idle(); #1;
        chk("R7 disabled timeout", status_o[8], 0);
        rx_to_expire = 1; step();
        idle(); #1;
        chk("R7 timeout set", status_o[8], 1);
        cmd_to_restart = 1; step();
        idle(); #1;
        chk("R7 restart clears", status_o[8], 0);
        // R10 same bit enabled and disabled together ends 0
        ien_we = 1; ien_bits = 10'h018; idis_we = 1; idis_bits = 10'h010; step();
        idle(); #1;
        chk("R10 disable wins", mask_o, 10'h008);
        // R11 irq one cycle after masked status
        dma_rx_done = 1; #1;
        chk("R11 irq not yet", irq_o, 0);
        step();
        #1;
        chk("R11 irq raised", irq_o, 1);
        idle(); step();
        #1;
        chk("R11 irq dropped", irq_o, 0);

        for (int i = 0; i < RAND_CYCLES; i++) begin
            randomize_inputs();
            step();
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule